// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM Core

This block is a clocked memory with a small internal array. Each word holds 36 bits in four 9-bit byte lanes. It reproduces the control behaviour of a synchronous burst SRAM. All control, address and write-data inputs are sampled on the rising clock edge. The read path adds no output register: the word addressed by an edge is presented during the cycle that follows that same edge.

Every edge is decoded as one of five operations, listed here in priority order:

1. Sleep, when the snooze input is high.
2. Deselect, when a new access is requested while any chip enable is inactive.
3. Start of a burst at the external address.
4. Step of the burst to the next address.
5. Hold of the burst at its current address.

Two address strobes can start a burst:

- The processor strobe always starts a read.
- The controller strobe starts a read or a write, chosen by the write inputs in that same cycle.

A 2-bit counter on the low address bits steps through the burst in linear order and wraps within an aligned group of four.

The data bus is split into a sampled input word, an output word and a drive-enable output. The drive enable is the tristate control. Output enable and snooze both act on it asynchronously.

Top module: `fts_burst_sram`

## Requirements
- R1: While reset (rst_n low) is asserted, and after its release until the first read operation, dq_oe is low.
- R2: When a new access is requested with any chip enable inactive, the edge is a deselect. A new access is either the processor strobe low together with ce_n low, or the controller strobe low. A chip enable is inactive when ce_n is high, ce2_n is high or ce2 is low. After a deselect, dq_oe is low and the burst is ended, so later step or hold cycles neither drive the bus nor write.
- R3: With snooze high, dq_oe is low at once, without waiting for a clock edge. An edge taken while snooze is high writes nothing.
- R4: The processor strobe low with the chip selected loads the external address and starts a read burst. The write inputs of that cycle are ignored, and the addressed word is left unchanged.
- R5: The controller strobe low, with the processor strobe not starting an access and the chip selected, loads the external address. The edge writes if the write condition holds and reads otherwise.
- R6: The write condition holds when gw_n is low, which writes all four lanes. It also holds when bwe_n is low and at least one bw_n bit is low, which writes only those lanes. With gw_n and bwe_n both high, nothing is written, whatever bw_n is.
- R7: bw_n bit i enables lane i, which is data bits [9*i+8 : 9*i]. Bit 9*i+8 is the parity bit of lane i.
- R8: With both strobes high, adv_n low and a burst live, the burst steps. The two low address bits increment modulo 4, the upper bits stay fixed, and the chip enables are ignored. The step is a write if the write condition holds and a read otherwise.
- R9: With both strobes high, adv_n high and a burst live, the burst holds. The address is unchanged, and the edge is a read or a write as in R8.
- R10: dq_oe is high only after a read operation, and only while oe_n is low and snooze is low. oe_n acts without a clock edge.
- R11: dq_o carries the word at the address chosen by the most recent edge, in the cycle right after that edge (flow-through).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2_n | input | 1 | Second chip enable, active low |
| ce2 | input | 1 | Second chip enable, active high |
| ads_proc_n | input | 1 | Processor address strobe, active low, read-only start |
| ads_ctrl_n | input | 1 | Controller address strobe, active low, read or write start |
| adv_n | input | 1 | Burst advance, low steps and high holds |
| addr | input | ADDR_W | External word address |
| bw_n | input | LANES | Byte-lane write enables, active low |
| bwe_n | input | 1 | Byte-write master enable, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| snooze | input | 1 | Power-down request, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*LANE_W | Write data, sampled on the edge |
| dq_o | output | LANES*LANE_W | Read data |
| dq_oe | output | 1 | Bus drive enable, high drives dq_o |

## Verification
Two functions can fall in the same cycle:

- A start of a burst from the processor strobe, with the write inputs asserted alongside it.
- A step of a burst that writes while the chip enables are inactive.

The bench provokes the first by asserting bwe_n and bw_n low, with different data, in the cycle that the processor strobe starts a read. It judges the result by confirming that the returned word still equals the reference model. The bench also writes through snooze and a deselect, and checks that the model value survives and that the drive enable drops at once.

// File: rtl/fts_burst_pkg.sv
package fts_burst_pkg;
   typedef enum logic [2:0] {
      OP_SLEEP = 3'd0,
      OP_DESEL = 3'd1,
      OP_START = 3'd2,
      OP_NEXT  = 3'd3,
      OP_HOLD  = 3'd4
   } burst_op_e;
endpackage

// File: rtl/fts_cycle_decode.sv
module fts_cycle_decode
   import fts_burst_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             snooze,
   input  logic             ce_n,
   input  logic             ce2_n,
   input  logic             ce2,
   input  logic             ads_proc_n,
   input  logic             ads_ctrl_n,
   input  logic             adv_n,
   input  logic [LANES-1:0] bw_n,
   input  logic             bwe_n,
   input  logic             gw_n,
   output burst_op_e        op,
   output logic             is_write,
   output logic [LANES-1:0] lane_en
);
   logic selected, start_p, start_c, want_wr;

   always_comb begin
      selected = !ce_n && !ce2_n && ce2;
      start_p  = !ads_proc_n && !ce_n;
      start_c  = !ads_ctrl_n && !start_p;

      if (!gw_n)       lane_en = '1;
      else if (!bwe_n) lane_en = ~bw_n;
      else             lane_en = '0;
      want_wr = |lane_en;

      is_write = 1'b0;
      if (snooze) begin
         op = OP_SLEEP;
      end else if ((start_p || start_c) && !selected) begin
         op = OP_DESEL;
      end else if (start_p) begin
         op = OP_START;
      end else if (start_c) begin
         op       = OP_START;
         is_write = want_wr;
      end else if (!adv_n) begin
         op       = OP_NEXT;
         is_write = want_wr;
      end else begin
         op       = OP_HOLD;
         is_write = want_wr;
      end
   end
endmodule

// File: rtl/fts_burst_counter.sv
module fts_burst_counter
   import fts_burst_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  burst_op_e         op,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic              tgt_valid,
   output logic [ADDR_W-1:0] addr_q,
   output logic              live_q
);
   localparam int HI_W = ADDR_W - BURST_W;

   logic [BURST_W-1:0] low_next;
   logic [HI_W-1:0]    high_cur;

   always_comb begin
      low_next  = addr_q[BURST_W-1:0] + BURST_W'(1);
      high_cur  = addr_q[ADDR_W-1:BURST_W];
      tgt_addr  = addr_q;
      tgt_valid = 1'b0;
      unique case (op)
         OP_START: begin
            tgt_addr  = ext_addr;
            tgt_valid = 1'b1;
         end
         OP_NEXT: begin
            tgt_addr  = {high_cur, low_next};
            tgt_valid = live_q;
         end
         OP_HOLD:  tgt_valid = live_q;
         default:  tgt_valid = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         live_q <= 1'b0;
      end else begin
         if (op == OP_DESEL) live_q <= 1'b0;
         if (op == OP_START) live_q <= 1'b1;
         if (tgt_valid)      addr_q <= tgt_addr;
      end
   end
endmodule

// File: rtl/fts_lane_array.sv
module fts_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [LANES-1:0]        lane_en,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we && lane_en[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
   end
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
   import fts_burst_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int LANES   = 4,
   parameter int LANE_W  = 9,
   parameter int BURST_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ce_n,
   input  logic                    ce2_n,
   input  logic                    ce2,
   input  logic                    ads_proc_n,
   input  logic                    ads_ctrl_n,
   input  logic                    adv_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        bw_n,
   input  logic                    bwe_n,
   input  logic                    gw_n,
   input  logic                    snooze,
   input  logic                    oe_n,
   input  logic [LANES*LANE_W-1:0] dq_i,
   output logic [LANES*LANE_W-1:0] dq_o,
   output logic                    dq_oe
);
   if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
      $error("BURST_W must lie between 1 and ADDR_W-1");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
      $error("LANES and LANE_W must be positive");
   end
   if (ADDR_W > 12) begin : g_bad_depth
      $error("ADDR_W too large for the internal array");
   end

   burst_op_e          op;
   logic               is_write;
   logic [LANES-1:0]   lane_en;
   logic [ADDR_W-1:0]  tgt_addr;
   logic               tgt_valid;
   logic [ADDR_W-1:0]  burst_addr;
   logic               burst_live;
   logic               read_live;

   fts_cycle_decode #(.LANES(LANES)) u_dec (
      .snooze(snooze), .ce_n(ce_n), .ce2_n(ce2_n), .ce2(ce2),
      .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
      .bw_n(bw_n), .bwe_n(bwe_n), .gw_n(gw_n),
      .op(op), .is_write(is_write), .lane_en(lane_en)
   );

   fts_burst_counter #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .op(op), .ext_addr(addr),
      .tgt_addr(tgt_addr), .tgt_valid(tgt_valid),
      .addr_q(burst_addr), .live_q(burst_live)
   );

   fts_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk(clk), .we(tgt_valid && is_write), .lane_en(lane_en),
      .waddr(tgt_addr), .wdata(dq_i), .raddr(burst_addr), .rdata(dq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              read_live <= 1'b0;
      else if (op != OP_SLEEP) read_live <= tgt_valid && !is_write;
      else                     read_live <= 1'b0;
   end

   assign dq_oe = read_live && !oe_n && !snooze;
endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk #(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              ce2_n,
   input logic              ce2,
   input logic              ads_proc_n,
   input logic              ads_ctrl_n,
   input logic              adv_n,
   input logic [ADDR_W-1:0] addr,
   input logic              snooze,
   input logic              oe_n,
   input logic              dq_oe,
   input logic [ADDR_W-1:0] burst_addr,
   input logic              burst_live,
   input logic              read_live
);
   always_comb begin
      if (!rst_n) p_reset_quiet_r1: assert (!dq_oe);
      if (snooze) p_snooze_hiz_r3: assert (!dq_oe);
      if (oe_n)   p_oe_gate_r10: assert (!dq_oe);
   end

   p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!snooze && ((!ads_proc_n && !ce_n) || !ads_ctrl_n) && (ce_n || ce2_n || !ce2))
      |=> (!read_live && !burst_live));

   p_proc_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!snooze && !ads_proc_n && !ce_n && !ce2_n && ce2)
      |=> (read_live && burst_addr == $past(addr)));

   p_step_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!snooze && ads_proc_n && ads_ctrl_n && !adv_n && burst_live)
      |=> (burst_addr[BURST_W-1:0] == BURST_W'($past(burst_addr[BURST_W-1:0]) + 1'b1)
           && burst_addr[ADDR_W-1:BURST_W] == $past(burst_addr[ADDR_W-1:BURST_W])));

   p_hold_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!snooze && ads_proc_n && ads_ctrl_n && adv_n && burst_live)
      |=> $stable(burst_addr));
endmodule

bind fts_burst_sram fts_burst_sram_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2_n(ce2_n), .ce2(ce2),
   .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
   .addr(addr), .snooze(snooze), .oe_n(oe_n), .dq_oe(dq_oe),
   .burst_addr(burst_addr), .burst_live(burst_live), .read_live(read_live)
);

// File: tb/fts_burst_sram_tb_top.sv
module fts_burst_sram_tb_top;
   localparam int AW = 6;
   localparam int DW = 36;

   typedef struct packed {
      logic [2:0]    op;
      logic [AW-1:0] a;
      logic [3:0]    bw;
      logic [DW-1:0] d;
      logic          eoe;
      logic [AW-1:0] ea;
   } vec_t;

   // op: 1 proc start (write inputs active), 2 ctrl read, 3 ctrl write,
   //     4 step read (enables off), 5 step write (enables off), 6 hold read, 7 deselect
   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{3'd3, 6'd8,  4'b0000, 36'h0_1234_5678, 1'b0, 6'd8},
      '{3'd5, 6'd0,  4'b0000, 36'h1_1111_1111, 1'b0, 6'd9},
      '{3'd5, 6'd0,  4'b0000, 36'h2_AAAA_5555, 1'b0, 6'd10},
      '{3'd5, 6'd0,  4'b0000, 36'h3_0F0F_F0F0, 1'b0, 6'd11},
      '{3'd1, 6'd8,  4'b0000, 36'hF_DEAD_BEEF, 1'b1, 6'd8},
      '{3'd4, 6'd0,  4'b1111, 36'h0,           1'b1, 6'd9},
      '{3'd6, 6'd0,  4'b1111, 36'h0,           1'b1, 6'd9},
      '{3'd4, 6'd0,  4'b1111, 36'h0,           1'b1, 6'd10},
      '{3'd4, 6'd0,  4'b1111, 36'h0,           1'b1, 6'd11},
      '{3'd4, 6'd0,  4'b1111, 36'h0,           1'b1, 6'd8},
      '{3'd3, 6'd10, 4'b1010, 36'hE_7777_9999, 1'b0, 6'd10},
      '{3'd2, 6'd10, 4'b1111, 36'h0,           1'b1, 6'd10},
      '{3'd7, 6'd12, 4'b1111, 36'h0,           1'b0, 6'd10},
      '{3'd4, 6'd0,  4'b1111, 36'h0,           1'b0, 6'd10}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n, ce2_n, ce2, ads_proc_n, ads_ctrl_n, adv_n, bwe_n, gw_n, snooze, oe_n;
   logic [AW-1:0] addr;
   logic [3:0]    bw_n;
   logic [DW-1:0] dq_i, dq_o;
   logic          dq_oe;
   logic [DW-1:0] model [64];
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fts_burst_sram dut_i (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce2_n(ce2_n), .ce2(ce2),
      .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
      .addr(addr), .bw_n(bw_n), .bwe_n(bwe_n), .gw_n(gw_n),
      .snooze(snooze), .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      ce_n = 1'b0; ce2_n = 1'b0; ce2 = 1'b1;
      ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
      bwe_n = 1'b1; gw_n = 1'b1; bw_n = 4'hF; snooze = 1'b0; oe_n = 1'b0;
      addr = '0; dq_i = '0;
   endtask

   task automatic model_wr(input logic [AW-1:0] a, input logic [3:0] en, input logic [DW-1:0] d);
      for (int i = 0; i < 4; i++)
         if (en[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
   endtask

   task automatic edge_step();
      @(posedge clk);
      #2;
   endtask

   function automatic string tag_of(input logic [2:0] op);
      case (op)
         3'd1: return "R4";
         3'd2: return "R5";
         3'd3: return "R7";
         3'd4: return "R8";
         3'd5: return "R8";
         3'd6: return "R9";
         default: return "R2";
      endcase
   endfunction

   initial begin
      #(20 * 5000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) model[i] = '0;
      idle();
      #15;
      chk("R1 drive during reset", DW'(dq_oe), '0);
      @(negedge clk);
      rst_n = 1'b1;
      #12;
      chk("R1 drive after reset", DW'(dq_oe), '0);

      // table walk; each row is one edge, result sampled just after it (R11)
      for (int v = 0; v < NV; v++) begin
         idle();
         addr = VECS[v].a;
         dq_i = VECS[v].d;
         case (VECS[v].op)
            3'd1: begin ads_proc_n = 1'b0; bwe_n = 1'b0; bw_n = 4'h0; end
            3'd2: ads_ctrl_n = 1'b0;
            3'd3: begin ads_ctrl_n = 1'b0; bwe_n = 1'b0; bw_n = VECS[v].bw; end
            3'd4: begin adv_n = 1'b0; ce_n = 1'b1; ce2 = 1'b0; end
            3'd5: begin adv_n = 1'b0; ce_n = 1'b1; ce2 = 1'b0; bwe_n = 1'b0; bw_n = VECS[v].bw; end
            3'd6: ce2_n = 1'b1;
            default: begin ads_ctrl_n = 1'b0; ce_n = 1'b1; end
         endcase
         if (VECS[v].op == 3'd3 || VECS[v].op == 3'd5) model_wr(VECS[v].ea, ~VECS[v].bw, VECS[v].d);
         edge_step();
         chk(tag_of(VECS[v].op), DW'(dq_oe), DW'(VECS[v].eoe));
         if (VECS[v].eoe) chk("R11 flow-through data", dq_o, model[VECS[v].ea]);
      end

      // R6: global write covers all lanes with bwe_n high
      idle(); ads_ctrl_n = 1'b0; addr = 6'd20; gw_n = 1'b0; dq_i = 36'hC_3C3C_A5A5;
      model_wr(6'd20, 4'hF, dq_i);
      edge_step();
      chk("R6 gw write no drive", DW'(dq_oe), '0);
      // R6/R5: bw_n low but bwe_n and gw_n high is a read, no write
      idle(); ads_ctrl_n = 1'b0; addr = 6'd20; bw_n = 4'h0; dq_i = 36'h5_5555_0000;
      edge_step();
      chk("R5 ctrl read drives", DW'(dq_oe), 36'd1);
      chk("R6 no write without bwe", dq_o, model[20]);

      // R10: oe_n acts with no clock edge
      oe_n = 1'b1; #2;
      chk("R10 oe_n high releases", DW'(dq_oe), '0);
      oe_n = 1'b0; #2;
      chk("R10 oe_n low drives", DW'(dq_oe), 36'd1);

      // R3: snooze drops drive at once and blocks writes
      snooze = 1'b1; #2;
      chk("R3 snooze immediate", DW'(dq_oe), '0);
      ads_ctrl_n = 1'b0; addr = 6'd8; gw_n = 1'b0; dq_i = 36'h9_9999_9999;
      edge_step();
      chk("R3 snooze after edge", DW'(dq_oe), '0);
      idle(); ads_proc_n = 1'b0; addr = 6'd8;
      edge_step();
      chk("R3 no write in snooze", dq_o, model[8]);

      // R2: processor start with active-high enable low is a deselect
      idle(); ads_proc_n = 1'b0; ce2 = 1'b0; addr = 6'd9;
      edge_step();
      chk("R2 deselect ce2 low", DW'(dq_oe), '0);
      // R2: step write after deselect must not land
      idle(); adv_n = 1'b0; gw_n = 1'b0; dq_i = 36'h7_0000_0007;
      edge_step();
      chk("R2 no drive after deselect", DW'(dq_oe), '0);
      idle(); ads_proc_n = 1'b0; addr = 6'd9;
      edge_step();
      chk("R2 no write after deselect", dq_o, model[9]);
      idle(); ads_proc_n = 1'b0; addr = 6'd8;
      edge_step();
      chk("R2 no write after deselect", dq_o, model[8]);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule